// File: doc/BRIEF.md
# 4:2:2 Component Video Stream Splitter

This block takes a multiplexed 4:2:2 component video stream, one word per clock, and separates it into three parallel channels: luma (Y), blue-difference chroma (Cb) and red-difference chroma (Cr). Words arrive in a repeating four-word cycle. A Cb, Y, Cr triplet shares one sample site, and a second, isolated Y word follows it. Every word is routed by its position in the cycle only. Ancillary words, timing-reference codes and active video are all handled the same way.

An internal phase counter follows the four-word cycle. A sync input aligns the counter: sync is high on one clock and low on the next, and the word present on that second clock is taken as Cb. The sync pulse may be given once, after which the counter free-runs, or it may be given before every Cb word. Both uses give the same output. Until the first such pulse has been seen, the block produces no strobes.

Each completed triplet is presented on all three outputs with both the luma and chroma strobes high. The isolated Y follows on the next cycle with only the luma strobe high, so luma runs at twice the chroma rate. The outputs are held between strobes. The strobes appear a fixed number of register stages after the word that completes them.

Top module: `vid422_splitter`

## Requirements
- R1: While reset is asserted, and right after it, `y_vld`, `c_vld` and `locked` are 0 and `y_out`, `cb_out` and `cr_out` are all zero.
- R2: Counting from an aligned Cb word, the words are routed by position: position 0 goes to `cb_out`, position 1 to `y_out` together with the triplet, position 2 to `cr_out`, and position 3 to `y_out` alone. The pattern then repeats.
- R3: `sync_in` high on one clock and low on the next aligns the phase, and the word on the low clock is taken as Cb. `locked` goes to 1 at the clock edge that samples this low.
- R4: Before the first alignment, `y_vld` and `c_vld` stay 0 whatever words arrive.
- R5: A triplet is output with `y_vld` and `c_vld` both 1, OUT_STAGES clock cycles after the edge that samples its Cr word. `c_vld` is never high on two consecutive cycles, and never without `y_vld`.
- R6: The isolated Y is output on the cycle right after its triplet, with `y_vld` 1 and `c_vld` 0.
- R7: `cb_out` and `cr_out` change only on cycles with `c_vld` high, and `y_out` changes only on cycles with `y_vld` high. On a luma-only strobe, `cb_out` and `cr_out` still show the preceding triplet.
- R8: A stream aligned once and left to free-run gives the same outputs as the same stream with a sync pulse before every Cb word.
- R9: A sync pulse that arrives in the middle of a cycle realigns the phase at once. The partial triplet from before the realignment is dropped and never output.
- R10: All 10-bit word values pass through unchanged, including 0x000, 0x3FF, timing-reference patterns and 8-bit data that has its two LSBs at zero.
- R11: Once `locked` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vid_word | input | W (10) | Multiplexed 4:2:2 word, MSB at bit W-1 |
| sync_in | input | 1 | Alignment input; a high-then-low pulse marks a Cb word |
| y_out | output | W (10) | Luma sample, held between strobes |
| cb_out | output | W (10) | Blue-difference sample, held between strobes |
| cr_out | output | W (10) | Red-difference sample, held between strobes |
| y_vld | output | 1 | Luma strobe |
| c_vld | output | 1 | Chroma strobe; always comes with `y_vld` |
| locked | output | 1 | Phase has been aligned at least once since reset |

## Verification
The assertions check every cycle that strobes stay silent before alignment, that chroma strobes come with luma and never back to back, that a luma-only strobe follows a triplet, that outputs hold between strobes, and that `locked` never drops. Only the bench scenarios can show that each word lands on the right channel with the right latency. The same holds for free-run and per-word sync giving the same result, for a mid-cycle realignment dropping the broken triplet, and for extreme and 8-bit values passing through bit-exact.

// File: rtl/vid422_pkg.sv
package vid422_pkg;

  // Position of a word inside the four-word multiplex cycle.
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_YC = 2'd1,  // luma cosited with the chroma pair
    PH_CR = 2'd2,
    PH_YI = 2'd3   // isolated luma
  } phase_e;

  function automatic phase_e phase_step(input phase_e cur);
    phase_e nxt;
    unique case (cur)
      PH_CB:   nxt = PH_YC;
      PH_YC:   nxt = PH_CR;
      PH_CR:   nxt = PH_YI;
      default: nxt = PH_CB;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/vid422_rst_sync.sv
module vid422_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign rst_n_out = chain_q[DEPTH-1];

endmodule

// File: rtl/vid422_phase_trk.sv
module vid422_phase_trk
  import vid422_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_in,
  output phase_e phase_cur,
  output logic   active,
  output logic   locked
);

  logic   sync_q,   sync_n;
  phase_e phase_q,  phase_n;
  logic   locked_q, locked_n;
  logic   sync_fall;

  // A sampled low after a sampled high marks the current word as Cb.
  always_comb begin
    sync_fall = sync_q & ~sync_in;
    phase_cur = sync_fall ? PH_CB : phase_q;
    active    = locked_q | sync_fall;
    sync_n    = sync_in;
    phase_n   = phase_step(phase_cur);
    locked_n  = locked_q | sync_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      phase_q  <= PH_CB;
      locked_q <= 1'b0;
    end else begin
      sync_q   <= sync_n;
      phase_q  <= phase_n;
      locked_q <= locked_n;
    end
  end

  assign locked = locked_q;

endmodule

// File: rtl/vid422_capture.sv
module vid422_capture
  import vid422_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  phase_e       phase_cur,
  input  logic [W-1:0] word_in,
  output logic         y_vld,
  output logic         c_vld,
  output logic [W-1:0] y_o,
  output logic [W-1:0] cb_o,
  output logic [W-1:0] cr_o
);

  logic [W-1:0] cb_hold_q, cb_hold_n;
  logic [W-1:0] yc_hold_q, yc_hold_n;
  logic         cb_hold_en, yc_hold_en;
  logic         grp_en, lum_en;
  logic [W-1:0] y_q,  y_n;
  logic [W-1:0] cb_q, cb_n;
  logic [W-1:0] cr_q, cr_n;
  logic         yv_q, yv_n;
  logic         cv_q, cv_n;

  // Enables written out per phase.
  always_comb begin
    cb_hold_en = active && (phase_cur == PH_CB);
    yc_hold_en = active && (phase_cur == PH_YC);
    grp_en     = active && (phase_cur == PH_CR);
    lum_en     = active && (phase_cur == PH_YI);
  end

  always_comb begin
    cb_hold_n = cb_hold_en ? word_in : cb_hold_q;
    yc_hold_n = yc_hold_en ? word_in : yc_hold_q;
    y_n       = y_q;
    cb_n      = cb_q;
    cr_n      = cr_q;
    yv_n      = 1'b0;
    cv_n      = 1'b0;
    if (grp_en) begin
      y_n  = yc_hold_q;
      cb_n = cb_hold_q;
      cr_n = word_in;
      yv_n = 1'b1;
      cv_n = 1'b1;
    end else if (lum_en) begin
      y_n  = word_in;
      yv_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_hold_q <= '0;
      yc_hold_q <= '0;
      y_q       <= '0;
      cb_q      <= '0;
      cr_q      <= '0;
      yv_q      <= 1'b0;
      cv_q      <= 1'b0;
    end else begin
      cb_hold_q <= cb_hold_n;
      yc_hold_q <= yc_hold_n;
      y_q       <= y_n;
      cb_q      <= cb_n;
      cr_q      <= cr_n;
      yv_q      <= yv_n;
      cv_q      <= cv_n;
    end
  end

  assign y_vld = yv_q;
  assign c_vld = cv_q;
  assign y_o   = y_q;
  assign cb_o  = cb_q;
  assign cr_o  = cr_q;

endmodule

// File: rtl/vid422_out_pipe.sv
module vid422_out_pipe #(
  parameter int W      = 10,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         y_vld_i,
  input  logic         c_vld_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] cb_i,
  input  logic [W-1:0] cr_i,
  output logic         y_vld_o,
  output logic         c_vld_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] cb_o,
  output logic [W-1:0] cr_o
);

  localparam int BW = 3 * W + 2;

  logic [BW-1:0] bundle_in;
  logic [BW-1:0] bundle_out;

  assign bundle_in = {y_vld_i, c_vld_i, y_i, cb_i, cr_i};

  generate
    if (STAGES == 0) begin : g_thru
      assign bundle_out = bundle_in;
    end else begin : g_regs
      logic [BW-1:0] stg_q [STAGES];
      logic [BW-1:0] stg_n [STAGES];

      always_comb begin
        stg_n[0] = bundle_in;
        for (int i = 1; i < STAGES; i++) begin
          stg_n[i] = stg_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) begin
            stg_q[i] <= '0;
          end
        end else begin
          for (int i = 0; i < STAGES; i++) begin
            stg_q[i] <= stg_n[i];
          end
        end
      end

      assign bundle_out = stg_q[STAGES-1];
    end
  endgenerate

  assign {y_vld_o, c_vld_o, y_o, cb_o, cr_o} = bundle_out;

endmodule

// File: rtl/vid422_splitter.sv
module vid422_splitter
  import vid422_pkg::*;
#(
  parameter int W          = 10,
  parameter int OUT_STAGES = 2,
  parameter int RST_DEPTH  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vid_word,
  input  logic         sync_in,
  output logic [W-1:0] y_out,
  output logic [W-1:0] cb_out,
  output logic [W-1:0] cr_out,
  output logic         y_vld,
  output logic         c_vld,
  output logic         locked
);

  // The capture stage is the first output register; the pipe adds the rest.
  localparam int EXTRA_STAGES = OUT_STAGES - 1;

  logic         rst_core_n;
  phase_e       phase_cur;
  logic         active;
  logic         cap_yv, cap_cv;
  logic [W-1:0] cap_y, cap_cb, cap_cr;

  vid422_rst_sync #(.DEPTH(RST_DEPTH)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  vid422_phase_trk u_phase (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sync_in   (sync_in),
    .phase_cur (phase_cur),
    .active    (active),
    .locked    (locked)
  );

  vid422_capture #(.W(W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .active    (active),
    .phase_cur (phase_cur),
    .word_in   (vid_word),
    .y_vld     (cap_yv),
    .c_vld     (cap_cv),
    .y_o       (cap_y),
    .cb_o      (cap_cb),
    .cr_o      (cap_cr)
  );

  vid422_out_pipe #(.W(W), .STAGES(EXTRA_STAGES)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .y_vld_i (cap_yv),
    .c_vld_i (cap_cv),
    .y_i     (cap_y),
    .cb_i    (cap_cb),
    .cr_i    (cap_cr),
    .y_vld_o (y_vld),
    .c_vld_o (c_vld),
    .y_o     (y_out),
    .cb_o    (cb_out),
    .cr_o    (cr_out)
  );

endmodule

// File: rtl/vid422_splitter_chk.sv
module vid422_splitter_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         y_vld,
  input logic         c_vld,
  input logic         locked,
  input logic [W-1:0] y_out,
  input logic [W-1:0] cb_out,
  input logic [W-1:0] cr_out
);

  // R4: silent until aligned
  a_r4_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!y_vld && !c_vld));

  // R5: chroma always comes with luma
  a_r5_chroma_with_luma: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |-> y_vld);

  // R5: no back-to-back chroma strobes
  a_r5_chroma_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |=> !c_vld);

  // R6: a luma-only strobe directly follows a triplet
  a_r6_isolated_after_group: assert property (@(posedge clk) disable iff (!rst_n)
    (y_vld && !c_vld) |-> $past(c_vld));

  // R7: chroma outputs hold between chroma strobes
  a_r7_chroma_held: assert property (@(posedge clk) disable iff (!rst_n)
    !c_vld |-> ($stable(cb_out) && $stable(cr_out)));

  // R7: luma output holds between luma strobes
  a_r7_luma_held: assert property (@(posedge clk) disable iff (!rst_n)
    !y_vld |-> $stable(y_out));

  // R11: alignment flag is sticky
  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

endmodule

bind vid422_splitter vid422_splitter_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .y_vld  (y_vld),
  .c_vld  (c_vld),
  .locked (locked),
  .y_out  (y_out),
  .cb_out (cb_out),
  .cr_out (cr_out)
);

// File: tb/vid422_splitter_tb_top.sv
module vid422_splitter_tb_top;

  localparam int W   = 10;
  localparam int LAT = 2;

  typedef struct {
    bit          lum_only;
    logic [W-1:0] y;
    logic [W-1:0] cb;
    logic [W-1:0] cr;
    longint      at;
    string       tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] vid_word;
  logic         sync_in;
  logic [W-1:0] y_out, cb_out, cr_out;
  logic         y_vld, c_vld, locked;

  longint cyc;
  int     n_checks;
  int     n_fails;
  bit     done;
  exp_t   expq[$];

  vid422_splitter #(.W(W), .OUT_STAGES(LAT)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_word (vid_word),
    .sync_in  (sync_in),
    .y_out    (y_out),
    .cb_out   (cb_out),
    .cr_out   (cr_out),
    .y_vld    (y_vld),
    .c_vld    (c_vld),
    .locked   (locked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // Monitor: compares each strobe with the next expected item.
  always @(negedge clk) begin
    if (rst_n && y_vld) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4/R9", "unexpected strobe, y_out", y_out, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(c_vld == !e.lum_only, e.tag, "c_vld", c_vld, !e.lum_only);
        chk(y_out == e.y, e.tag, "y_out", y_out, e.y);
        chk(cb_out == e.cb, e.tag, "cb_out", cb_out, e.cb);
        chk(cr_out == e.cr, e.tag, "cr_out", cr_out, e.cr);
        chk(cyc == e.at, e.tag, "strobe cycle", cyc, e.at);
      end
    end
  end

  task automatic put(input logic [W-1:0] w, input logic s);
    @(negedge clk);
    vid_word = w;
    sync_in  = s;
  endtask

  // Driver: one four-word cycle; s_last drives sync on the isolated Y word.
  task automatic send_group(input logic [W-1:0] cb, input logic [W-1:0] yc,
                            input logic [W-1:0] cr, input logic [W-1:0] yi,
                            input logic s_last, input string tag);
    exp_t e;
    put(cb, 1'b0);
    put(yc, 1'b0);
    put(cr, 1'b0);
    e.lum_only = 1'b0; e.y = yc; e.cb = cb; e.cr = cr; e.at = cyc + LAT; e.tag = tag;
    expq.push_back(e);
    put(yi, s_last);
    e.lum_only = 1'b1; e.y = yi; e.at = cyc + LAT;
    expq.push_back(e);
  endtask

  // Watchdog
  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    rst_n    = 1'b0;
    sync_in  = 1'b0;
    vid_word = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(!y_vld && !c_vld, "R1", "strobes in reset", {y_vld, c_vld}, 0);
    chk(!locked, "R1", "locked in reset", locked, 0);
    chk(y_out == 0 && cb_out == 0 && cr_out == 0, "R1", "data in reset", y_out | cb_out | cr_out, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!locked && !y_vld, "R1", "after release", {locked, y_vld}, 0);

    // R4: unaligned traffic, sync held low
    for (int i = 0; i < 12; i++) put(W'(10'h080 + i * 7), 1'b0);
    repeat (LAT + 1) @(negedge clk);
    chk(!locked, "R4", "locked before sync", locked, 0);

    // R3: single alignment pulse, then free-run (R2, R5, R6, R8)
    put(10'h040, 1'b1);
    send_group(10'h200, 10'h0A0, 10'h1F0, 10'h0B4, 1'b0, "R2");
    chk(locked, "R3", "locked after pulse", locked, 1);
    send_group(10'h180, 10'h2C0, 10'h240, 10'h311, 1'b0, "R8");
    send_group(10'h0F8, 10'h155, 10'h2AA, 10'h0F0, 1'b0, "R8");
    send_group(10'h233, 10'h3AC, 10'h1C7, 10'h040, 1'b1, "R6");

    // R8: same data, pulse before every Cb
    send_group(10'h180, 10'h2C0, 10'h240, 10'h311, 1'b1, "R8");
    send_group(10'h0F8, 10'h155, 10'h2AA, 10'h0F0, 1'b1, "R8");
    send_group(10'h233, 10'h3AC, 10'h1C7, 10'h040, 1'b0, "R8");

    // R9: broken cycle (Cb, Y only) then realign on the next word
    put(10'h111, 1'b0);
    put(10'h222, 1'b1);
    send_group(10'h1A5, 10'h2B6, 10'h3C7, 10'h0D8, 1'b0, "R9");
    send_group(10'h0E9, 10'h1FA, 10'h20B, 10'h31C, 1'b0, "R9");

    // R10: extreme values, timing-reference pattern, 8-bit data
    send_group(10'h3FF, 10'h000, 10'h000, 10'h2D8, 1'b0, "R10");
    send_group(10'h000, 10'h3FF, 10'h3FF, 10'h000, 1'b0, "R10");
    send_group(10'h1FC, 10'h2A4, 10'h0C8, 10'h3FC, 1'b0, "R10");
    send_group(10'h200, 10'h040, 10'h200, 10'h3AC, 1'b0, "R7");

    // Let the last strobes leave, then reset
    repeat (LAT) @(negedge clk);
    @(negedge clk);
    chk(locked, "R11", "locked held through run", locked, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!locked && !y_vld && !c_vld, "R1", "after mid-run reset", {locked, y_vld, c_vld}, 0);
    chk(expq.size() == 0, "R5", "pending expected items", expq.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule